// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns one operand reference of a CPU with a 24-bit address space into its effective address. It also reports how many internal penalty cycles the reference costs. The CPU supplies the following inputs:

- the addressing-mode code;
- the operand bytes that follow the opcode;
- any pointer that it has already fetched from memory for indirect modes;
- the register file: direct-page base, X and Y indexes, stack pointer, data bank, program bank and the PC after the operand;
- the emulation flag and the index-width flag;
- the access kind.

The block fetches no memory and decodes no opcodes.

The inputs are captured on a one-cycle valid strobe. A two-state controller moves from `S_IDLE` to `S_DONE` on the edge that captures a request. `S_DONE` lasts one cycle. From `S_DONE` the controller returns to `S_IDLE`, or it stays in `S_DONE` when another request arrives back to back. The address and penalty count are registered on the capture edge. They hold their value until the next request or reset. `done` is high exactly while the controller is in `S_DONE`.

Top module: `opnd_addr_gen`

## Requirements
- R1: A synchronous reset drives `ea` to 0, `pen` to 0 and `done` to 0.
- R2: A request sampled with `valid` high at a clock edge shows its result on `ea`/`pen` after that edge, with `done` high for the following cycle. Without `valid`, `ea` and `pen` keep their value and `done` falls.
- R3: Mode code 0 (direct page): `ea` = {8'h00, (D + zero-extended operand byte 0) mod 2^16}. `pen` = 1 when D[7:0] is nonzero, otherwise 0.
- R4: Mode codes 1 (direct,X) and 2 (direct,Y), page wrap not in force: the full 16-bit index is added to the R3 sum, modulo 2^16, in bank 0. `pen` = 1, plus 1 more when D[7:0] is nonzero.
- R5: Modes 1 and 2 with `emu`=1 and D[7:0]=0: only the index low byte is added to the low byte of the R3 sum. The carry is dropped and the high byte is kept. `pen` = 1.
- R6: Mode code 3 (absolute): `ea` = {DB, operand[15:0]}, `pen` = 0.
- R7: Mode codes 4 (absolute,X) and 5 (absolute,Y): `ea` = ({DB, operand[15:0]} + index) mod 2^24. `pen` is 1 when any of these holds:
  - `acc` is write (1) or modify (2);
  - `idx8`=0;
  - operand[7:0] + index[7:0] ≥ 0x100.

  Otherwise `pen` is 0. Access codes: 0 read, 1 write, 2 modify, 3 jump.
- R8: Mode code 6 (stack relative): `ea` = {8'h00, (S + operand byte 0) mod 2^16}, `pen` = 1.
- R9: Mode code 7 (stack relative indirect, Y): `ea` = ({DB, 16'h0000} + pointer[15:0] + Y) mod 2^24, `pen` = 1.
- R10: Mode code 8 (short branch): `ea` = {PB, (PC + sign-extended operand byte 0) mod 2^16}. Mode code 9 (long branch): `ea` = {PB, (PC + operand[15:0]) mod 2^16}. Both give `pen` = 0.
- R11: Mode code 10 (long,X): `ea` = (operand[23:0] + X) mod 2^24. Mode code 11 (indirect long,Y): `ea` = (pointer[23:0] + Y) mod 2^24. Both give `pen` = 0.
- R12: Mode codes 12 to 15 are reserved and give `ea` = 0 and `pen` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Request strobe; all other inputs sampled with it |
| mode | input | 4 | Addressing-mode code (R3 to R12) |
| acc | input | 2 | Access kind: 0 read, 1 write, 2 modify, 3 jump |
| opnd | input | 24 | Operand bytes, first byte in bits 7:0 |
| ptr | input | 24 | Pointer already fetched for indirect modes 7 and 11 |
| dpage | input | 16 | Direct-page base D |
| xidx | input | 16 | Index X |
| yidx | input | 16 | Index Y |
| sptr | input | 16 | Stack pointer S |
| dbank | input | 8 | Data bank DB |
| pbank | input | 8 | Program bank PB |
| pc | input | 16 | Program counter after the operand bytes |
| emu | input | 1 | Emulation flag |
| idx8 | input | 1 | 1 when the index registers are 8 bits wide |
| ea | output | 24 | Effective address |
| pen | output | 2 | Extra internal cycles |
| done | output | 1 | One-cycle result strobe |

## Verification
The address path and the penalty path are separate adders and comparators. A defect in either one shows as a miscompare on `ea` or `pen` in the cycle right after the request edge; no other output is involved. A controller stuck in the wrong state shows on `done` within one cycle, either as a missing strobe or as a strobe with no request. Such a fault moves the scoreboard pairing out of step for every later request. Stale output registers are caught by the hold check and the mid-run reset check.

// File: rtl/oag_pkg.sv
package oag_pkg;
    localparam int ADDR_W = 24;
    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;
    localparam int PEN_W  = 2;

    typedef enum logic [3:0] {
        M_DIR   = 4'd0,
        M_DIRX  = 4'd1,
        M_DIRY  = 4'd2,
        M_ABS   = 4'd3,
        M_ABSX  = 4'd4,
        M_ABSY  = 4'd5,
        M_STK   = 4'd6,
        M_STKIY = 4'd7,
        M_BRS   = 4'd8,
        M_BRL   = 4'd9,
        M_LONGX = 4'd10,
        M_DILY  = 4'd11
    } mode_e;

    typedef enum logic [1:0] {
        A_READ   = 2'd0,
        A_WRITE  = 2'd1,
        A_MODIFY = 2'd2,
        A_JUMP   = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_INDEX = 2'd1,
        K_STKPT = 2'd2,
        K_LONG  = 2'd3
    } abs_kind_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_DONE = 1'b1
    } state_e;
endpackage

// File: rtl/oag_direct.sv
// Bank-0 address unit: direct page, direct indexed and stack relative.
module oag_direct #(
    parameter int RW = 16,
    parameter int BW = 8,
    parameter int PW = 2
) (
    input  logic          sel_idx,
    input  logic          use_stack,
    input  logic          emu,
    input  logic [BW-1:0] off,
    input  logic [RW-1:0] dp,
    input  logic [RW-1:0] idx,
    input  logic [RW-1:0] sp,
    output logic [RW-1:0] addr,
    output logic [PW-1:0] pen
);
    localparam int HW = RW - BW;

    logic          dl_nz;
    logic [RW-1:0] off_x;
    logic [RW-1:0] base;
    logic [RW-1:0] full;
    logic [BW-1:0] lo_wrap;

    always_comb begin
        off_x   = {{HW{1'b0}}, off};
        dl_nz   = |dp[BW-1:0];
        base    = dp + off_x;
        full    = base + idx;
        lo_wrap = base[BW-1:0] + idx[BW-1:0];
        if (use_stack) begin
            addr = sp + off_x;
            pen  = PW'(1);
        end else if (!sel_idx) begin
            addr = base;
            pen  = PW'(dl_nz);
        end else begin
            // page wrap only in emulation with a page-aligned base
            addr = (emu && !dl_nz) ? {base[RW-1:BW], lo_wrap} : full;
            pen  = PW'(dl_nz) + PW'(1);
        end
    end
endmodule

// File: rtl/oag_absolute.sv
// Banked address unit: absolute, absolute indexed, stack pointer indexed, long indexed.
module oag_absolute #(
    parameter int AW = 24,
    parameter int RW = 16,
    parameter int BW = 8,
    parameter int PW = 2
) (
    input  oag_pkg::abs_kind_e kind,
    input  logic               wr,
    input  logic               idx16,
    input  logic [AW-RW-1:0]   bank,
    input  logic [RW-1:0]      off,
    input  logic [AW-1:0]      lng,
    input  logic [RW-1:0]      idx,
    output logic [AW-1:0]      addr,
    output logic [PW-1:0]      pen
);
    import oag_pkg::*;

    localparam int BKW = AW - RW;

    logic [AW-1:0] abs_base;
    logic [AW-1:0] idx_x;
    logic [AW-1:0] off_x;
    logic [BW:0]   lo_sum;

    always_comb begin
        abs_base = {bank, off};
        idx_x    = {{BKW{1'b0}}, idx};
        off_x    = {{BKW{1'b0}}, off};
        lo_sum   = {1'b0, off[BW-1:0]} + {1'b0, idx[BW-1:0]};
        unique case (kind)
            K_PLAIN: begin
                addr = abs_base;
                pen  = '0;
            end
            K_INDEX: begin
                addr = abs_base + idx_x;
                pen  = PW'(wr | idx16 | lo_sum[BW]);
            end
            K_STKPT: begin
                addr = {bank, {RW{1'b0}}} + off_x + idx_x;
                pen  = PW'(1);
            end
            K_LONG: begin
                addr = lng + idx_x;
                pen  = '0;
            end
            default: begin
                addr = '0;
                pen  = '0;
            end
        endcase
    end
endmodule

// File: rtl/oag_branch.sv
// Branch target adder, wraps within the program bank.
module oag_branch #(
    parameter int RW = 16,
    parameter int BW = 8
) (
    input  logic          is_long,
    input  logic [RW-1:0] off,
    input  logic [RW-1:0] pc,
    output logic [RW-1:0] tgt
);
    logic [RW-1:0] disp;

    always_comb begin
        disp = is_long ? off : {{(RW-BW){off[BW-1]}}, off[BW-1:0]};
        tgt  = pc + disp;
    end
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen #(
    parameter int AW = oag_pkg::ADDR_W,
    parameter int RW = oag_pkg::REG_W,
    parameter int BW = oag_pkg::BYTE_W,
    parameter int PW = oag_pkg::PEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic [3:0]    mode,
    input  logic [1:0]    acc,
    input  logic [AW-1:0] opnd,
    input  logic [AW-1:0] ptr,
    input  logic [RW-1:0] dpage,
    input  logic [RW-1:0] xidx,
    input  logic [RW-1:0] yidx,
    input  logic [RW-1:0] sptr,
    input  logic [BW-1:0] dbank,
    input  logic [BW-1:0] pbank,
    input  logic [RW-1:0] pc,
    input  logic          emu,
    input  logic          idx8,
    output logic [AW-1:0] ea,
    output logic [PW-1:0] pen,
    output logic          done
);
    import oag_pkg::*;

    localparam int BKW = AW - RW;

    mode_e     m;
    acc_e      a;
    state_e    state, nxt;
    abs_kind_e akind;
    logic      use_y, d_idx, d_stk, is_wr, br_long;
    logic [RW-1:0] idx_sel, a_off, d_addr, b_tgt;
    logic [AW-1:0] a_lng, a_addr, ea_nxt;
    logic [PW-1:0] d_pen, a_pen, pen_nxt;

    // decode of mode and access kind into unit controls
    always_comb begin
        m       = mode_e'(mode);
        a       = acc_e'(acc);
        use_y   = (m == M_DIRY) || (m == M_ABSY) || (m == M_STKIY) || (m == M_DILY);
        idx_sel = use_y ? yidx : xidx;
        d_idx   = (m == M_DIRX) || (m == M_DIRY);
        d_stk   = (m == M_STK);
        is_wr   = (a == A_WRITE) || (a == A_MODIFY);
        br_long = (m == M_BRL);
        a_off   = (m == M_STKIY) ? ptr[RW-1:0] : opnd[RW-1:0];
        a_lng   = (m == M_DILY) ? ptr : opnd;
        unique case (m)
            M_ABSX, M_ABSY:  akind = K_INDEX;
            M_STKIY:         akind = K_STKPT;
            M_LONGX, M_DILY: akind = K_LONG;
            default:         akind = K_PLAIN;
        endcase
    end

    oag_direct #(.RW(RW), .BW(BW), .PW(PW)) u_dir (
        .sel_idx   (d_idx),
        .use_stack (d_stk),
        .emu       (emu),
        .off       (opnd[BW-1:0]),
        .dp        (dpage),
        .idx       (idx_sel),
        .sp        (sptr),
        .addr      (d_addr),
        .pen       (d_pen)
    );

    oag_absolute #(.AW(AW), .RW(RW), .BW(BW), .PW(PW)) u_abs (
        .kind  (akind),
        .wr    (is_wr),
        .idx16 (!idx8),
        .bank  (dbank),
        .off   (a_off),
        .lng   (a_lng),
        .idx   (idx_sel),
        .addr  (a_addr),
        .pen   (a_pen)
    );

    oag_branch #(.RW(RW), .BW(BW)) u_br (
        .is_long (br_long),
        .off     (opnd[RW-1:0]),
        .pc      (pc),
        .tgt     (b_tgt)
    );

    // result select
    always_comb begin
        unique case (m)
            M_DIR, M_DIRX, M_DIRY, M_STK: begin
                ea_nxt  = {{BKW{1'b0}}, d_addr};
                pen_nxt = d_pen;
            end
            M_ABS, M_ABSX, M_ABSY, M_STKIY, M_LONGX, M_DILY: begin
                ea_nxt  = a_addr;
                pen_nxt = a_pen;
            end
            M_BRS, M_BRL: begin
                ea_nxt  = {pbank, b_tgt};
                pen_nxt = '0;
            end
            default: begin
                ea_nxt  = '0;
                pen_nxt = '0;
            end
        endcase
    end

    // next-state logic
    always_comb begin
        unique case (state)
            S_IDLE:  nxt = valid ? S_DONE : S_IDLE;
            S_DONE:  nxt = valid ? S_DONE : S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ea  <= '0;
            pen <= '0;
        end else if (valid) begin
            ea  <= ea_nxt;
            pen <= pen_nxt;
        end
    end

    assign done = (state == S_DONE);
endmodule

// File: rtl/oag_chk.sv
module oag_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid,
    input logic [3:0]  mode,
    input logic [15:0] dpage,
    input logic [7:0]  pbank,
    input logic [23:0] ea,
    input logic [1:0]  pen,
    input logic        done
);
    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ea == 24'h0 && pen == 2'd0 && !done));

    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> done);

    // R2
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(valid));

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |=> ($stable(ea) && $stable(pen)));

    // R3
    dir_pen_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && mode == 4'd0) |=> (pen == {1'b0, |$past(dpage[7:0])}));

    // R8
    stk_pen_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && mode == 4'd6) |=> (pen == 2'd1 && ea[23:16] == 8'h00));

    // R10
    br_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && (mode == 4'd8 || mode == 4'd9)) |=> (ea[23:16] == $past(pbank) && pen == 2'd0));

    // R12
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && mode >= 4'd12) |=> (ea == 24'h0 && pen == 2'd0));
endmodule

bind opnd_addr_gen oag_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .valid (valid),
    .mode  (mode),
    .dpage (dpage),
    .pbank (pbank),
    .ea    (ea),
    .pen   (pen),
    .done  (done)
);

// File: tb/sim_opnd_addr_gen.sv
module sim_opnd_addr_gen;
    // 8-unit period at 1 ns units: 125 MHz
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  acc = '0;
    logic [23:0] opnd = '0, ptr = '0;
    logic [15:0] dpage = '0, xidx = '0, yidx = '0, sptr = '0, pc = '0;
    logic [7:0]  dbank = '0, pbank = '0;
    logic        emu = 1'b0, idx8 = 1'b1;
    logic [23:0] ea;
    logic [1:0]  pen;
    logic        done;

    int vecs = 0;
    int errs = 0;

    typedef struct {
        logic [23:0] ea;
        logic [1:0]  pen;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    opnd_addr_gen u0 (
        .clk(clk), .rst(rst), .valid(valid), .mode(mode), .acc(acc),
        .opnd(opnd), .ptr(ptr), .dpage(dpage), .xidx(xidx), .yidx(yidx),
        .sptr(sptr), .dbank(dbank), .pbank(pbank), .pc(pc), .emu(emu),
        .idx8(idx8), .ea(ea), .pen(pen), .done(done)
    );

    // model written from the requirements
    function automatic logic [25:0] model(
        input logic [3:0] m, input logic [1:0] a, input logic [23:0] op,
        input logic [23:0] pt, input logic [15:0] d, input logic [15:0] x,
        input logic [15:0] y, input logic [15:0] s, input logic [7:0] db,
        input logic [7:0] pb, input logic [15:0] p, input logic e, input logic i8);
        logic [15:0] t, ix;
        logic [23:0] r;
        logic [1:0]  c;
        logic [8:0]  lo;
        logic        dnz;
        ix  = (m == 4'd2 || m == 4'd5 || m == 4'd7 || m == 4'd11) ? y : x;
        dnz = (d[7:0] != 8'h00);
        r = '0; c = '0;
        case (m)
            4'd0: begin t = d + {8'h00, op[7:0]}; r = {8'h00, t}; c = dnz ? 2'd1 : 2'd0; end
            4'd1, 4'd2: begin
                t = d + {8'h00, op[7:0]};
                if (e && !dnz) t[7:0] = t[7:0] + ix[7:0];
                else           t = t + ix;
                r = {8'h00, t};
                c = dnz ? 2'd2 : 2'd1;
            end
            4'd3: r = {db, op[15:0]};
            4'd4, 4'd5: begin
                r  = {db, op[15:0]} + {8'h00, ix};
                lo = {1'b0, op[7:0]} + {1'b0, ix[7:0]};
                c  = (a == 2'd1 || a == 2'd2 || !i8 || lo >= 9'h100) ? 2'd1 : 2'd0;
            end
            4'd6: begin t = s + {8'h00, op[7:0]}; r = {8'h00, t}; c = 2'd1; end
            4'd7: begin r = {db, 16'h0000} + {8'h00, pt[15:0]} + {8'h00, ix}; c = 2'd1; end
            4'd8: begin t = p + {{8{op[7]}}, op[7:0]}; r = {pb, t}; end
            4'd9: begin t = p + op[15:0]; r = {pb, t}; end
            4'd10: r = op + {8'h00, ix};
            4'd11: r = pt + {8'h00, ix};
            default: r = '0;
        endcase
        return {c, r};
    endfunction

    task automatic send(input logic [3:0] m, input logic [1:0] a, input logic [23:0] op,
                        input logic [23:0] pt, input logic [15:0] d, input logic [15:0] x,
                        input logic [15:0] y, input logic [15:0] s, input logic [7:0] db,
                        input logic [7:0] pb, input logic [15:0] p, input logic e,
                        input logic i8, input string tag);
        logic [25:0] exp_v;
        @(negedge clk);
        mode = m; acc = a; opnd = op; ptr = pt; dpage = d; xidx = x; yidx = y;
        sptr = s; dbank = db; pbank = pb; pc = p; emu = e; idx8 = i8;
        valid = 1'b1;
        exp_v = model(m, a, op, pt, d, x, y, s, db, pb, p, e, i8);
        sb.push_back('{exp_v[23:0], exp_v[25:24], tag});
        @(negedge clk);
        valid = 1'b0;
    endtask

    // monitor: pairs each done strobe with the oldest expected item
    always @(negedge clk) begin
        if (!rst && done) begin
            vecs++;
            if (sb.size() == 0) begin
                errs++;
                $display("FAIL R2 done with no request: ea=%h pen=%0d expected no strobe", ea, pen);
            end else begin
                exp_t it;
                it = sb.pop_front();
                if (ea !== it.ea || pen !== it.pen) begin
                    errs++;
                    $display("FAIL %s: ea=%h pen=%0d expected ea=%h pen=%0d",
                             it.tag, ea, pen, it.ea, it.pen);
                end
            end
        end
    end

    task automatic check_idle(input logic [23:0] xea, input logic [1:0] xpen, input string tag);
        vecs++;
        if (ea !== xea || pen !== xpen || done !== 1'b0) begin
            errs++;
            $display("FAIL %s: ea=%h pen=%0d done=%b expected ea=%h pen=%0d done=0",
                     tag, ea, pen, done, xea, xpen);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle(24'h0, 2'd0, "R1 reset state");
        rst = 1'b0;

        //   mode  acc  opnd        ptr         D        X        Y        S        DB     PB     PC
        send(4'd0, 2'd0, 24'h000034, 24'h0, 16'h1200, 16'h0, 16'h0, 16'h0, 8'h7E, 8'h00, 16'h0, 1'b0, 1'b1, "R3 direct aligned D");
        send(4'd0, 2'd0, 24'h000002, 24'h0, 16'h12FF, 16'h0, 16'h0, 16'h0, 8'h7E, 8'h00, 16'h0, 1'b0, 1'b1, "R3 direct unaligned D");
        send(4'd1, 2'd0, 24'h0000F0, 24'h0, 16'h0000, 16'h0020, 16'h0, 16'h0, 8'h00, 8'h00, 16'h0, 1'b0, 1'b1, "R4 direct,X native");
        send(4'd2, 2'd0, 24'h0000F0, 24'h0, 16'h0105, 16'h0, 16'h0020, 16'h0, 8'h00, 8'h00, 16'h0, 1'b1, 1'b1, "R4 direct,Y emu unaligned D");
        send(4'd2, 2'd0, 24'h0000FF, 24'h0, 16'hFF00, 16'h0, 16'h0101, 16'h0, 8'h00, 8'h00, 16'h0, 1'b0, 1'b0, "R4 direct,Y 16-bit wrap");
        send(4'd1, 2'd0, 24'h0000F0, 24'h0, 16'h0100, 16'h0020, 16'h0, 16'h0, 8'h00, 8'h00, 16'h0, 1'b1, 1'b1, "R5 direct,X page wrap");
        send(4'd2, 2'd0, 24'h000080, 24'h0, 16'h0300, 16'h0, 16'h1290, 16'h0, 8'h00, 8'h00, 16'h0, 1'b1, 1'b1, "R5 direct,Y page wrap high index ignored");
        send(4'd3, 2'd3, 24'h001234, 24'h0, 16'h0, 16'h0, 16'h0, 16'h0, 8'h7E, 8'h00, 16'h0, 1'b0, 1'b1, "R6 absolute");
        send(4'd4, 2'd0, 24'h0012F8, 24'h0, 16'h0, 16'h0010, 16'h0, 16'h0, 8'h7E, 8'h00, 16'h0, 1'b0, 1'b1, "R7 abs,X page cross");
        send(4'd4, 2'd0, 24'h001210, 24'h0, 16'h0, 16'h0005, 16'h0, 16'h0, 8'h7E, 8'h00, 16'h0, 1'b0, 1'b1, "R7 abs,X read no cross");
        send(4'd5, 2'd1, 24'h001210, 24'h0, 16'h0, 16'h0, 16'h0005, 16'h0, 8'h7E, 8'h00, 16'h0, 1'b0, 1'b1, "R7 abs,Y write");
        send(4'd4, 2'd2, 24'h001210, 24'h0, 16'h0, 16'h0005, 16'h0, 16'h0, 8'h7E, 8'h00, 16'h0, 1'b0, 1'b1, "R7 abs,X modify");
        send(4'd5, 2'd0, 24'h001210, 24'h0, 16'h0, 16'h0, 16'h0105, 16'h0, 8'h7E, 8'h00, 16'h0, 1'b0, 1'b0, "R7 abs,Y 16-bit index");
        send(4'd4, 2'd0, 24'h00FFF0, 24'h0, 16'h0, 16'h0020, 16'h0, 16'h0, 8'h7E, 8'h00, 16'h0, 1'b0, 1'b1, "R7 abs,X bank carry");
        send(4'd6, 2'd0, 24'h000020, 24'h0, 16'h0, 16'h0, 16'h0, 16'h01F0, 8'h7E, 8'h00, 16'h0, 1'b1, 1'b1, "R8 stack relative");
        send(4'd7, 2'd0, 24'h000003, 24'h00FFF0, 16'h0, 16'h0, 16'h0020, 16'h01F0, 8'hFF, 8'h00, 16'h0, 1'b0, 1'b1, "R9 stack indirect,Y 24-bit wrap");
        send(4'd8, 2'd0, 24'h0000FE, 24'h0, 16'h0, 16'h0, 16'h0, 16'h0, 8'h00, 8'h12, 16'h8000, 1'b0, 1'b1, "R10 short branch back");
        send(4'd8, 2'd3, 24'h000020, 24'h0, 16'h0, 16'h0, 16'h0, 16'h0, 8'h00, 8'h12, 16'hFFF0, 1'b0, 1'b1, "R10 short branch wrap");
        send(4'd9, 2'd3, 24'h00FF00, 24'h0, 16'h0, 16'h0, 16'h0, 16'h0, 8'h00, 8'h34, 16'h0010, 1'b0, 1'b1, "R10 long branch");
        send(4'd10, 2'd0, 24'h7EFFFF, 24'h0, 16'h0, 16'h0002, 16'h0, 16'h0, 8'h00, 8'h00, 16'h0, 1'b0, 1'b1, "R11 long,X");
        send(4'd11, 2'd0, 24'h000000, 24'hFFFFFF, 16'h0, 16'h0, 16'h0001, 16'h0, 8'h00, 8'h00, 16'h0, 1'b0, 1'b1, "R11 indirect long,Y wrap");
        send(4'd13, 2'd1, 24'h123456, 24'h654321, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h55, 8'h66, 16'h7777, 1'b0, 1'b0, "R12 reserved code");
        send(4'd3, 2'd0, 24'h00ABCD, 24'h0, 16'h0, 16'h0, 16'h0, 16'h0, 8'h21, 8'h00, 16'h0, 1'b0, 1'b1, "R6 absolute before hold");

        // outputs hold with no request
        repeat (4) @(negedge clk);
        check_idle(24'h21ABCD, 2'd0, "R2 hold without request");

        // reset in mid run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_idle(24'h0, 2'd0, "R1 reset after activity");

        repeat (2) @(negedge clk);
        if (sb.size() != 0) begin
            errs++;
            $display("FAIL R2 missing done: %0d pending expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule